// File: doc/BRIEF.md
# Dual-Mode Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It divides a local-oscillator input by a programmable ratio N and emits one pulse for every N input cycles, which a phase comparator then uses. The block runs on a fast system clock. Each local-oscillator input arrives as a one-cycle strobe (`hb_tick`, `mb_tick`, `lb_tick`), and each strobe stands for one input cycle on that path.

Two control bits choose one of three counting paths:
- **High band** (`band_hi=1`, `direct_sel` ignored): the strobes pass through a fixed divide-by-two prescaler before the counter, so the effective ratio is twice the set value.
- **Mid band** (`band_hi=0`, `direct_sel=1`): the strobes are counted directly using the full 16-bit word.
- **Low band** (`band_hi=0`, `direct_sel=0`): the 12-bit divisor is taken from bits 15..4 of the word.

An inhibit input stops the divider entirely. A control state machine sequences the block through three states:
- `ST_HALT`: inhibited, no counting. Moves to `ST_ARM` once inhibit is low.
- `ST_ARM`: the counter, the path and the prescaler are loaded fresh. This state lasts one cycle and then moves to `ST_RUN`.
- `ST_RUN`: counting. Stays in `ST_RUN` until inhibit rises.

Any state returns to `ST_HALT` whenever `inhibit` is high.

Top module: `fbdiv_top`

## Requirements
- R1: After reset, `div_pulse` is low and stays low while no strobe arrives.
- R2: In high-band mode (`band_hi=1`), one pulse is produced for every 2×N `hb_tick` strobes, where N is the 16-bit `div_word`. A set value of 2014 gives 4028 strobes per pulse.
- R3: In mid-band mode (`band_hi=0`, `direct_sel=1`), one pulse is produced for every N `mb_tick` strobes, where N is the 16-bit `div_word`. A set value of 4440 gives 4440 strobes per pulse.
- R4: In low-band mode (`band_hi=0`, `direct_sel=0`), N is `div_word[15:4]` and bits 3..0 have no effect. A word of 0x091F gives 145 `lb_tick` strobes per pulse.
- R5: In high-band and mid-band modes, a set value below 272 is treated as 272.
- R6: In low-band mode, a 12-bit set value below 4 is treated as 4.
- R7: `div_pulse` is exactly one clock wide. It rises in the cycle after the strobe that completes a period and never follows a cycle without a strobe.
- R8: While `inhibit` is high, no pulse is produced, from the cycle after `inhibit` is sampled high onward. After release, counting restarts from a full period with a fresh prescaler phase.
- R9: A new `div_word` or mode written during a period takes effect only at the next terminal count. The period in progress completes with its old ratio and path.
- R10: Strobes on the two paths not selected for the current period are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inhibit | input | 1 | Stops counting and silences the output |
| band_hi | input | 1 | Selects the high-band path with the prescaler |
| direct_sel | input | 1 | When `band_hi=0`: 1 selects mid band, 0 selects low band |
| div_word | input | 16 | Divisor word; its LSB position depends on the mode |
| hb_tick | input | 1 | High-band input cycle strobe |
| mb_tick | input | 1 | Mid-band input cycle strobe |
| lb_tick | input | 1 | Low-band input cycle strobe |
| div_pulse | output | 1 | One-cycle pulse at terminal count |

## Verification
The assertions check several properties on every cycle:
- a pulse is single-cycle and is always preceded by a strobe;
- inhibit silences the output and forces the halt state;
- the decoded divisor never falls below the floor of its mode.

Other behaviour only the bench's scenarios can show. These are the exact strobe count per period in each mode, that the low nibble is ignored in low band, that a rewritten word or mode waits for the terminal count, and that strobes on unselected paths leave the period length unchanged. The bench also shows that a release from inhibit starts a full period.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    typedef enum logic [1:0] {
        PATH_HB = 2'd0,
        PATH_MB = 2'd1,
        PATH_LB = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } state_e;

endpackage

// File: rtl/fbdiv_mode_decode.sv
module fbdiv_mode_decode
    import fbdiv_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int LB_SHIFT   = 4,
    parameter int WIDE_MIN   = 272,
    parameter int NARROW_MIN = 4
) (
    input  logic              band_hi,
    input  logic              direct_sel,
    input  logic [WORD_W-1:0] div_word,
    output path_e             path_o,
    output logic [WORD_W-1:0] n_o
);
    localparam logic [WORD_W-1:0] WMIN = WORD_W'(WIDE_MIN);
    localparam logic [WORD_W-1:0] NMIN = WORD_W'(NARROW_MIN);

    logic [WORD_W-1:0] raw_n;
    logic [WORD_W-1:0] floor_n;

    always_comb begin
        if (band_hi)         path_o = PATH_HB;
        else if (direct_sel) path_o = PATH_MB;
        else                 path_o = PATH_LB;
    end

    always_comb begin
        if (path_o == PATH_LB) begin
            raw_n   = div_word >> LB_SHIFT;
            floor_n = NMIN;
        end else begin
            raw_n   = div_word;
            floor_n = WMIN;
        end
        n_o = (raw_n < floor_n) ? floor_n : raw_n;
    end

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
    parameter int PRE_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_tick,
    output logic out_tick
);
    generate
        if (PRE_DIV <= 1) begin : g_bypass
            assign out_tick = in_tick;
        end else begin : g_div
            localparam int PH_W = $clog2(PRE_DIV);
            localparam logic [PH_W-1:0] PH_LAST = PH_W'(PRE_DIV - 1);
            logic [PH_W-1:0] phase_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (clr) begin
                    phase_q <= '0;
                end else if (in_tick) begin
                    phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
                end
            end

            assign out_tick = in_tick && (phase_q == PH_LAST);
        end
    endgenerate

endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [CNT_W-1:0] reload_n,
    output logic             tc
);
    logic [CNT_W-1:0] cnt_q;

    assign tc = adv && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload_n - CNT_W'(1);
        end else if (adv) begin
            cnt_q <= tc ? (reload_n - CNT_W'(1)) : (cnt_q - CNT_W'(1));
        end
    end

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int LB_SHIFT   = 4,
    parameter int WIDE_MIN   = 272,
    parameter int NARROW_MIN = 4,
    parameter int PRE_DIV    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit,
    input  logic              band_hi,
    input  logic              direct_sel,
    input  logic [WORD_W-1:0] div_word,
    input  logic              hb_tick,
    input  logic              mb_tick,
    input  logic              lb_tick,
    output logic              div_pulse
);
    state_e            state_q, state_d;
    path_e             path_next, path_q;
    logic [WORD_W-1:0] n_next;
    logic              running, pre_in, pre_clr, pre_out;
    logic              sel_tick, adv, load, tc;

    fbdiv_mode_decode #(
        .WORD_W(WORD_W), .LB_SHIFT(LB_SHIFT),
        .WIDE_MIN(WIDE_MIN), .NARROW_MIN(NARROW_MIN)
    ) dec_i (
        .band_hi(band_hi), .direct_sel(direct_sel), .div_word(div_word),
        .path_o(path_next), .n_o(n_next)
    );

    always_comb begin
        state_d = ST_HALT;
        unique case (state_q)
            ST_HALT: state_d = inhibit ? ST_HALT : ST_ARM;
            ST_ARM:  state_d = inhibit ? ST_HALT : ST_RUN;
            ST_RUN:  state_d = inhibit ? ST_HALT : ST_RUN;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    assign running = (state_q == ST_RUN) && !inhibit;
    assign load    = (state_q == ST_ARM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          path_q <= PATH_MB;
        else if (load || tc) path_q <= path_next;
    end

    assign pre_in  = running && (path_q == PATH_HB) && hb_tick;
    assign pre_clr = (state_q != ST_RUN) || (path_q != PATH_HB);

    fbdiv_prescaler #(.PRE_DIV(PRE_DIV)) pre_i (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr),
        .in_tick(pre_in), .out_tick(pre_out)
    );

    always_comb begin
        case (path_q)
            PATH_HB: sel_tick = pre_out;
            PATH_MB: sel_tick = mb_tick;
            PATH_LB: sel_tick = lb_tick;
            default: sel_tick = 1'b0;
        endcase
    end

    assign adv = running && sel_tick;

    fbdiv_counter #(.CNT_W(WORD_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .reload_n(n_next), .tc(tc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_pulse <= 1'b0;
        else        div_pulse <= tc;
    end

endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker
    import fbdiv_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int WIDE_MIN   = 272,
    parameter int NARROW_MIN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inhibit,
    input logic              hb_tick,
    input logic              mb_tick,
    input logic              lb_tick,
    input logic              div_pulse,
    input state_e            state,
    input path_e             path,
    input logic [WORD_W-1:0] n_next
);
    localparam logic [WORD_W-1:0] WMIN = WORD_W'(WIDE_MIN);
    localparam logic [WORD_W-1:0] NMIN = WORD_W'(NARROW_MIN);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    p_pulse_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> $past(hb_tick || mb_tick || lb_tick));

    p_inhibit_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !div_pulse);

    p_inhibit_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (state == ST_HALT));

    p_wide_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (path != PATH_LB) |-> (n_next >= WMIN));

    p_narrow_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (path == PATH_LB) |-> (n_next >= NMIN));

endmodule

bind fbdiv_top fbdiv_checker #(
    .WORD_W(WORD_W), .WIDE_MIN(WIDE_MIN), .NARROW_MIN(NARROW_MIN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit),
    .hb_tick(hb_tick), .mb_tick(mb_tick), .lb_tick(lb_tick),
    .div_pulse(div_pulse), .state(state_q), .path(path_next), .n_next(n_next)
);

// File: tb/fbdiv_top_tb_top.sv
module fbdiv_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inhibit = 1'b1;
    logic band_hi = 1'b0;
    logic direct_sel = 1'b1;
    logic [15:0] div_word = 16'd272;
    logic hb_tick = 1'b0, mb_tick = 1'b0, lb_tick = 1'b0;
    logic div_pulse;

    always #4 clk = ~clk;

    fbdiv_top dut_i (
        .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .band_hi(band_hi),
        .direct_sel(direct_sel), .div_word(div_word), .hb_tick(hb_tick),
        .mb_tick(mb_tick), .lb_tick(lb_tick), .div_pulse(div_pulse)
    );

    int checks = 0, fails = 0;
    int tick_count = 0, exp_cur = 0, exp_next = 0, periods = 0;
    int density = 100, cnt_path = 1, chg_at = 0;
    bit solo = 1'b0, measuring = 1'b0, drive_en = 1'b0, chg_armed = 1'b0, prev_pulse = 1'b0;
    logic chg_hi, chg_sns;
    logic [15:0] chg_word;
    string tag = "R1";

    function automatic int exp_div(input logic h, input logic s, input logic [15:0] w);
        int n;
        if (h) begin n = w; if (n < 272) n = 272; return 2 * n; end
        if (s) begin n = w; if (n < 272) n = 272; return n; end
        n = w >> 4; if (n < 4) n = 4; return n;
    endfunction

    task automatic chk(input bit ok, input string t, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, expv);
        end
    endtask

    task automatic step();
        bit t;
        @(negedge clk);
        if (div_pulse) begin
            if (prev_pulse) chk(1'b0, "R7 double-width pulse", 1, 0);
            if (measuring) begin
                chk(tick_count == exp_cur, tag, tick_count, exp_cur);
                tick_count = 0; exp_cur = exp_next; periods++;
            end else chk(1'b0, "R8 unexpected pulse", 1, 0);
        end
        prev_pulse = div_pulse;
        t = drive_en && (($urandom % 100) < density);
        if (solo) begin
            hb_tick = (cnt_path == 0) ? t : 1'($urandom % 2);
            mb_tick = (cnt_path == 1) ? t : 1'($urandom % 2);
            lb_tick = (cnt_path == 2) ? t : 1'($urandom % 2);
        end else begin
            hb_tick = t; mb_tick = t; lb_tick = t;
        end
        if (t) tick_count++;
        if (chg_armed && tick_count == chg_at) begin
            band_hi = chg_hi; direct_sel = chg_sns; div_word = chg_word; chg_armed = 1'b0;
        end
    endtask

    task automatic restart(input logic h, input logic s, input logic [15:0] w);
        measuring = 1'b0; drive_en = 1'b0; inhibit = 1'b1;
        repeat (4) step();
        band_hi = h; direct_sel = s; div_word = w;
        cnt_path = h ? 0 : (s ? 1 : 2);
        inhibit = 1'b0;
        repeat (3) step();
        tick_count = 0; periods = 0;
        exp_cur = exp_div(h, s, w); exp_next = exp_cur;
        measuring = 1'b1; drive_en = 1'b1;
    endtask

    task automatic run(input int nper);
        int guard = 0;
        while (periods < nper && guard < 40000) begin step(); guard++; end
        chk(periods >= nper, {tag, " period count"}, periods, nper);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R0 watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        inhibit = 1'b0;
        repeat (6) step();
        chk(div_pulse == 1'b0, "R1 reset output", div_pulse, 0);

        // R2 worked example with prescaler, one path strobed alone
        solo = 1'b1; density = 100; tag = "R2 high band 2014";
        restart(1'b1, 1'b0, 16'h07DE); run(2);
        // R3 worked example, direct count
        tag = "R3 mid band 4440";
        restart(1'b0, 1'b1, 16'h1158); run(2);
        // R4 worked example with garbage low nibble
        tag = "R4 low band 0x091F";
        restart(1'b0, 1'b0, 16'h091F); run(3);
        // R5 floors
        tag = "R5 mid band floor"; density = 70;
        restart(1'b0, 1'b1, 16'd100); run(2);
        tag = "R5 high band floor";
        restart(1'b1, 1'b1, 16'd5); run(2);
        // R6 floor, full-rate strobes for the pulse width case (R7)
        tag = "R6 and R7 low band floor"; density = 100;
        restart(1'b0, 1'b0, 16'h0025); run(5);
        // R10 unused paths toggle randomly while low band counts
        tag = "R10 unused paths"; density = 60;
        restart(1'b0, 1'b0, 16'h0283); run(3);

        // R8 inhibit mid period, then fresh full period after release
        tag = "R8 before inhibit";
        restart(1'b1, 1'b0, 16'd300);
        repeat (150) step();
        measuring = 1'b0; inhibit = 1'b1; density = 100;
        repeat (500) step();
        chk(div_pulse == 1'b0, "R8 inhibited output", div_pulse, 0);
        tag = "R8 after release";
        restart(1'b1, 1'b0, 16'd300); run(2);

        // R9 word and mode changes wait for terminal count
        solo = 1'b0; density = 80; tag = "R9 mid to low";
        restart(1'b0, 1'b1, 16'd400);
        chg_hi = 1'b0; chg_sns = 1'b0; chg_word = 16'h00A7;
        exp_next = exp_div(1'b0, 1'b0, 16'h00A7); chg_at = 150; chg_armed = 1'b1;
        run(3);
        tag = "R9 high to mid";
        restart(1'b1, 1'b0, 16'd300);
        chg_hi = 1'b0; chg_sns = 1'b1; chg_word = 16'd350;
        exp_next = exp_div(1'b0, 1'b1, 16'd350); chg_at = 200; chg_armed = 1'b1;
        run(3);

        // constrained random mix
        solo = 1'b1;
        for (int i = 0; i < 12; i++) begin
            int m = $urandom % 3;
            logic [15:0] w;
            if (m == 2) w = 16'((((4 + $urandom % 300)) << 4) | ($urandom % 16));
            else if ($urandom % 5 == 0) w = 16'($urandom % 272);
            else w = 16'(272 + $urandom % 500);
            density = 50 + $urandom % 51;
            tag = (m == 0) ? "R2 random" : ((m == 1) ? "R3 random" : "R4 random");
            restart(m == 0, m == 1, w); run(2);
        end

        measuring = 1'b0; drive_en = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule